// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides whether a received Ethernet frame is kept, based only on its 48-bit destination address. The receive path feeds the six destination bytes in wire order, marking the first one with a start-of-frame strobe. One cycle after the sixth byte, the block raises a single-cycle decision. The decision carries an accept bit, a multicast flag, a broadcast flag and a filter-fail flag.

The filter can compare the address against a programmed station address. It can also test one bit of a 64-bit multicast hash table. That bit is selected by the top six bits of a CRC-32 taken over the address. Five mode bits combine these checks:
- promiscuous;
- pass all multicast;
- hash enable;
- hash for every address;
- inverse filtering.

A sixth mode bit rejects broadcast frames. All of these values are loaded through a simple register write port.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `dec_valid`, `accept`, `is_mcast`, `is_bcast` and `filt_fail` are 0, and the station address, hash table and control bits are all 0. Address bytes that arrive before the first `sof` are ignored and produce no decision.
- R2: A byte is taken when `byte_valid` is 1. `sof` together with a byte marks it as destination byte 0. Idle cycles may sit between bytes. `dec_valid` is 1 for exactly one cycle, the cycle after the sixth byte is taken. While `dec_valid` is 0, the four result outputs are 0.
- R3: Register select 0 writes station bytes 3..0, with byte 0 in bits 7:0 and byte 3 in bits 31:24. Select 1 writes station bytes 5 and 4, with byte 5 in bits 15:8. With no mode bits set, a unicast frame is accepted exactly when all six bytes equal the station address. Byte 0 is the first byte received.
- R4: `is_mcast` is 1 when bit 0 of destination byte 0 is 1. `is_bcast` is 1 when all 48 address bits are 1.
- R5: The hash index is bits 31:26 of a CRC-32 computed over the six bytes. The CRC uses polynomial 0x04C11DB7, MSB-first shifting, an initial value of all ones and no final inversion. Each byte is taken LSB first. Select 2 writes hash bits 31:0 and select 3 writes hash bits 63:32. With control bit 13 set, a multicast frame whose indexed hash bit is 1 is accepted.
- R6: Control bit 19 accepts every multicast frame, whatever the hash table holds.
- R7: With control bits 13 and 15 both set, a unicast frame is accepted exactly when its indexed hash bit is 1. The station address is not consulted.
- R8: A broadcast frame is accepted unless control bit 11 is set. With bit 11 set, it is rejected.
- R9: Control bit 17 inverts the address-match result. `filt_fail` is 1 exactly when the inverted-or-not result is a reject.
- R10: Control bit 18 makes `accept` 1 for every frame. `filt_fail` still reports the address-match outcome.
- R11: A `sof` part way through a frame discards the partial address and starts a new one. Bytes after the sixth, without a new `sof`, are ignored.
- R12: The decision uses the register contents of the sixth-byte cycle. A write in that same cycle first affects the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sof | input | 1 | Start of frame; with `byte_valid`, the byte is address byte 0 |
| byte_valid | input | 1 | Address byte present on `byte_data` |
| byte_data | input | 8 | Destination address byte |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 station low, 1 station high, 2 hash low, 3 hash high, 4 control |
| reg_wdata | input | 32 | Register write data |
| dec_valid | output | 1 | Decision valid, one cycle |
| accept | output | 1 | Frame accepted |
| is_mcast | output | 1 | Destination is a group address |
| is_bcast | output | 1 | Destination is broadcast |
| filt_fail | output | 1 | Address filter rejected the frame |

## Verification
A register write and the completion of an address can land on the same cycle. The bench provokes this by driving the sixth byte together with a write of the promiscuous bit, for a frame that does not match. It then expects a reject for that frame and an accept for an identical frame sent next. A `sof` arriving part way through an address, or just after a finished one, is the other collision. It is judged by comparing the decision against the second address only.

// File: rtl/af_pkg.sv
// Package: shared constants, control-bit layout and the byte-wide CRC step
// for the receive address filter.
package af_pkg;
    localparam int ADDR_BYTES = 6;
    localparam int ADDR_W     = ADDR_BYTES * 8;
    localparam int HASH_IDX_W = 6;
    localparam int HASH_W     = 1 << HASH_IDX_W;
    localparam int CNT_W      = 3;
    localparam int CRC_W      = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;

    // Register select codes
    localparam logic [2:0] SEL_STA_LO  = 3'd0;
    localparam logic [2:0] SEL_STA_HI  = 3'd1;
    localparam logic [2:0] SEL_HASH_LO = 3'd2;
    localparam logic [2:0] SEL_HASH_HI = 3'd3;
    localparam logic [2:0] SEL_CTRL    = 3'd4;

    // Control word bit positions (software-visible layout)
    localparam int CB_BCAST_OFF = 11;
    localparam int CB_HASH_EN   = 13;
    localparam int CB_HASH_ALL  = 15;
    localparam int CB_INVERSE   = 17;
    localparam int CB_PROMISC   = 18;
    localparam int CB_ALL_MCAST = 19;

    typedef struct packed {
        logic bcast_off;
        logic hash_en;
        logic hash_all;
        logic inverse;
        logic promisc;
        logic all_mcast;
    } ctrl_t;

    // One byte of CRC-32, MSB-first register, data bits taken LSB first.
    function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c_in,
                                                  input logic [7:0] d);
        logic [CRC_W-1:0] c;
        logic fb;
        c = c_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[CRC_W-1] ^ d[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction
endpackage

// File: rtl/af_regs.sv
// Module: af_regs
// Holds the station address, multicast hash table and control bits.
// Assumes writes are single-cycle strobes; unknown selects are dropped.
module af_regs
    import af_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [ADDR_W-1:0] sta_addr,
    output logic [HASH_W-1:0] hash_tbl,
    output ctrl_t             ctrl
);
    // Register update on write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sta_addr <= '0;
            hash_tbl <= '0;
            ctrl     <= '0;
        end else if (reg_we) begin
            case (reg_sel)
                SEL_STA_LO:  sta_addr[31:0]      <= reg_wdata;
                SEL_STA_HI:  sta_addr[47:32]     <= reg_wdata[15:0];
                SEL_HASH_LO: hash_tbl[31:0]      <= reg_wdata;
                SEL_HASH_HI: hash_tbl[63:32]     <= reg_wdata;
                SEL_CTRL: begin
                    ctrl.bcast_off <= reg_wdata[CB_BCAST_OFF];
                    ctrl.hash_en   <= reg_wdata[CB_HASH_EN];
                    ctrl.hash_all  <= reg_wdata[CB_HASH_ALL];
                    ctrl.inverse   <= reg_wdata[CB_INVERSE];
                    ctrl.promisc   <= reg_wdata[CB_PROMISC];
                    ctrl.all_mcast <= reg_wdata[CB_ALL_MCAST];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/af_collect.sv
// Module: af_collect
// Assembles the destination address and runs the CRC byte by byte.
// Presents the complete address and hash index combinationally in the
// cycle the last byte is taken. Assumes sof may coincide with byte 0.
module af_collect
    import af_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sof,
    input  logic                  byte_valid,
    input  logic [7:0]            byte_data,
    output logic                  last,
    output logic [ADDR_W-1:0]     addr_full,
    output logic [HASH_IDX_W-1:0] hash_idx
);
    localparam logic [CNT_W-1:0] IDLE_CNT = CNT_W'(ADDR_BYTES);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ADDR_BYTES - 1);

    logic [CNT_W-1:0]  cnt_q, cnt_eff;
    logic [CRC_W-1:0]  crc_q, crc_base, crc_nx;
    logic [ADDR_W-1:0] addr_q, addr_nx;
    logic              take;

    // Effective position, base CRC and next address for this cycle
    always_comb begin
        cnt_eff  = sof ? '0 : cnt_q;
        crc_base = sof ? '1 : crc_q;
        take     = byte_valid && (cnt_eff < IDLE_CNT);
        crc_nx   = crc_byte(crc_base, byte_data);
        addr_nx  = addr_q;
        for (int i = 0; i < ADDR_BYTES; i++) begin
            if (cnt_eff == CNT_W'(i)) addr_nx[i*8 +: 8] = byte_data;
        end
    end

    assign last      = take && (cnt_eff == LAST_CNT);
    assign addr_full = addr_nx;
    assign hash_idx  = crc_nx[CRC_W-1 -: HASH_IDX_W];

    // Byte position, CRC state and address storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= IDLE_CNT;
            crc_q  <= '1;
            addr_q <= '0;
        end else if (take) begin
            cnt_q  <= cnt_eff + 1'b1;
            crc_q  <= crc_nx;
            addr_q <= addr_nx;
        end else if (sof) begin
            cnt_q  <= '0;
            crc_q  <= '1;
        end
    end
endmodule

// File: rtl/af_decide.sv
// Module: af_decide
// Combines station match, hash hit and mode bits into a registered
// decision pulse. Assumes 'fire' is a single-cycle strobe.
module af_decide
    import af_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fire,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [HASH_IDX_W-1:0] hash_idx,
    input  logic [ADDR_W-1:0]     sta_addr,
    input  logic [HASH_W-1:0]     hash_tbl,
    input  ctrl_t                 ctrl,
    output logic                  dec_valid,
    output logic                  accept,
    output logic                  is_mcast,
    output logic                  is_bcast,
    output logic                  filt_fail
);
    logic group, bcast, hit, perfect, match, filt_ok;

    // Address classification and match rule
    always_comb begin
        group   = addr[0];
        bcast   = &addr;
        hit     = hash_tbl[hash_idx];
        perfect = (addr == sta_addr);
        if (bcast)
            match = !ctrl.bcast_off;
        else if (group)
            match = ctrl.all_mcast || (ctrl.hash_en && hit) || perfect;
        else if (ctrl.hash_en && ctrl.hash_all)
            match = hit;
        else
            match = perfect;
        filt_ok = match ^ ctrl.inverse;
    end

    // Registered decision, all zero outside the valid cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            accept    <= 1'b0;
            is_mcast  <= 1'b0;
            is_bcast  <= 1'b0;
            filt_fail <= 1'b0;
        end else begin
            dec_valid <= fire;
            accept    <= fire && (ctrl.promisc || filt_ok);
            is_mcast  <= fire && group;
            is_bcast  <= fire && bcast;
            filt_fail <= fire && !filt_ok;
        end
    end
endmodule

// File: rtl/rx_addr_filter.sv
// Module: rx_addr_filter (top)
// Receive destination-address filter: register file, address collector
// and decision stage. Assumes the six destination bytes arrive in wire
// order with sof on the first.
module rx_addr_filter
    import af_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sof,
    input  logic        byte_valid,
    input  logic [7:0]  byte_data,
    input  logic        reg_we,
    input  logic [2:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic        dec_valid,
    output logic        accept,
    output logic        is_mcast,
    output logic        is_bcast,
    output logic        filt_fail
);
    logic [ADDR_W-1:0]     sta_addr;
    logic [HASH_W-1:0]     hash_tbl;
    ctrl_t                 ctrl_q;
    logic                  last;
    logic [ADDR_W-1:0]     addr_full;
    logic [HASH_IDX_W-1:0] hash_idx;

    af_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .sta_addr(sta_addr), .hash_tbl(hash_tbl),
        .ctrl(ctrl_q)
    );

    af_collect u_collect (
        .clk(clk), .rst_n(rst_n), .sof(sof), .byte_valid(byte_valid),
        .byte_data(byte_data), .last(last), .addr_full(addr_full),
        .hash_idx(hash_idx)
    );

    af_decide u_decide (
        .clk(clk), .rst_n(rst_n), .fire(last), .addr(addr_full),
        .hash_idx(hash_idx), .sta_addr(sta_addr), .hash_tbl(hash_tbl),
        .ctrl(ctrl_q), .dec_valid(dec_valid), .accept(accept),
        .is_mcast(is_mcast), .is_bcast(is_bcast), .filt_fail(filt_fail)
    );
endmodule

// File: rtl/af_checker.sv
// Module: af_checker
// Temporal properties of the filter, bound onto rx_addr_filter.
module af_checker
    import af_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  byte_valid,
    input logic  dec_valid,
    input logic  accept,
    input logic  is_mcast,
    input logic  is_bcast,
    input logic  filt_fail,
    input ctrl_t ctrl
);
    assert_dec_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(byte_valid));
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);
    assert_quiet_outputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !(accept || is_mcast || is_bcast || filt_fail));
    assert_bcast_is_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && is_bcast) |-> is_mcast);
    assert_promisc_accepts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && $past(ctrl.promisc)) |-> accept);
    assert_accept_tracks_fail_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !$past(ctrl.promisc)) |-> (accept == !filt_fail));
endmodule

bind rx_addr_filter af_checker u_chk (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .dec_valid(dec_valid),
    .accept(accept), .is_mcast(is_mcast), .is_bcast(is_bcast),
    .filt_fail(filt_fail), .ctrl(ctrl_q)
);

// File: tb/sim_rx_addr_filter.sv
// Directed bench for rx_addr_filter; one task per scenario.
module sim_rx_addr_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof = 1'b0, byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic dec_valid, accept, is_mcast, is_bcast, filt_fail;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [47:0] sh_sta  = '0;
    logic [63:0] sh_hash = '0;
    logic [31:0] sh_ctrl = '0;

    localparam logic [47:0] STA   = 48'h5F4E3D2C1B0A;
    localparam logic [47:0] OTHER = 48'h604E3D2C1B02;
    localparam logic [47:0] MCAST = 48'h3412005E0001;
    localparam logic [47:0] BCAST = 48'hFFFFFFFFFFFF;

    always #10 clk = ~clk;

    rx_addr_filter u0 (
        .clk(clk), .rst_n(rst_n), .sof(sof), .byte_valid(byte_valid),
        .byte_data(byte_data), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .dec_valid(dec_valid), .accept(accept),
        .is_mcast(is_mcast), .is_bcast(is_bcast), .filt_fail(filt_fail)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [47:0] a);
        logic [31:0] c = '1;
        logic fb;
        for (int i = 0; i < 48; i++) begin
            fb = c[31] ^ a[i];
            c = {c[30:0], 1'b0};
            if (fb) c = c ^ 32'h04C11DB7;
        end
        return c;
    endfunction

    function automatic int hidx(input logic [47:0] a);
        logic [31:0] c = ref_crc(a);
        return int'(c[31:26]);
    endfunction

    // Expected {accept, mcast, bcast, fail} from the requirements
    function automatic logic [3:0] ref_dec(input logic [47:0] a);
        logic grp = a[0], bc = &a, hit = sh_hash[hidx(a)], m, ok;
        if (bc) m = !sh_ctrl[11];
        else if (grp) m = sh_ctrl[19] || (sh_ctrl[13] && hit) || (a == sh_sta);
        else if (sh_ctrl[13] && sh_ctrl[15]) m = hit;
        else m = (a == sh_sta);
        ok = m ^ sh_ctrl[17];
        return {sh_ctrl[18] || ok, grp, bc, !ok};
    endfunction

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
        case (sel)
            3'd0: sh_sta[31:0] = d;
            3'd1: sh_sta[47:32] = d[15:0];
            3'd2: sh_hash[31:0] = d;
            3'd3: sh_hash[63:32] = d;
            3'd4: sh_ctrl = d;
            default: ;
        endcase
    endtask

    task automatic set_hash(input logic [63:0] h);
        wr(3'd2, h[31:0]); wr(3'd3, h[63:32]);
    endtask

    task automatic drive_byte(input logic s, input logic [7:0] b);
        @(negedge clk); sof = s; byte_valid = 1'b1; byte_data = b;
    endtask

    task automatic idle();
        @(negedge clk); sof = 1'b0; byte_valid = 1'b0;
    endtask

    // Sends six bytes, optional gap cycles; returns at the decision cycle
    task automatic send(input logic [47:0] a, input int gap);
        for (int i = 0; i < 6; i++) begin
            drive_byte(i == 0, a[i*8 +: 8]);
            if (i < 5) for (int g = 0; g < gap; g++) idle();
        end
        idle();
    endtask

    task automatic check_dec(input string req, input logic [47:0] a);
        chk({req, " valid"}, {31'd0, dec_valid}, 32'd1);
        chk({req, " result"}, {28'd0, accept, is_mcast, is_bcast, filt_fail},
            {28'd0, ref_dec(a)});
        idle();
        chk({req, " pulse end"}, {31'd0, dec_valid}, 32'd0);
    endtask

    task automatic frame(input string req, input logic [47:0] a, input int gap);
        send(a, gap);
        check_dec(req, a);
    endtask

    task automatic t_reset();
        chk("R1 outputs after reset", {27'd0, dec_valid, accept, is_mcast, is_bcast, filt_fail}, 32'd0);
        for (int i = 0; i < 8; i++) drive_byte(1'b0, 8'hA0 + 8'(i));
        idle();
        chk("R1 bytes before sof ignored", {31'd0, dec_valid}, 32'd0);
        frame("R1 zero registers reject unicast", STA, 0);
    endtask

    task automatic t_unicast();
        wr(3'd0, STA[31:0]); wr(3'd1, {16'hABCD, STA[47:32]});
        frame("R3 station match", STA, 0);
        frame("R3 station mismatch byte5", OTHER, 0);
        frame("R2 station match with gaps", STA, 2);
        frame("R3 mismatch byte0", {STA[47:8], 8'h0C}, 1);
    endtask

    task automatic t_flags();
        frame("R4 multicast flag", MCAST, 0);
        frame("R4 broadcast flag R8 accepted", BCAST, 0);
    endtask

    task automatic t_hash();
        int k = hidx(MCAST);
        logic [63:0] h = '0;
        wr(3'd4, 32'h1 << 13);
        h[k] = 1'b1;
        set_hash(h);
        frame("R5 hash hit accepts", MCAST, 0);
        set_hash(~h);
        frame("R5 other hash bits reject", MCAST, 0);
        chk("R5 reject expected", {31'd0, ref_dec(MCAST)[3]}, 32'd0);
    endtask

    task automatic t_passall();
        set_hash('0);
        wr(3'd4, 32'h1 << 19);
        frame("R6 pass all multicast", MCAST, 0);
        frame("R6 unicast still filtered", OTHER, 0);
    endtask

    task automatic t_hashonly();
        logic [63:0] h = '0;
        h[hidx(OTHER)] = 1'b1;
        set_hash(h);
        wr(3'd4, (32'h1 << 13) | (32'h1 << 15));
        frame("R7 unicast by hash", OTHER, 0);
        frame("R7 station by hash only", STA, 0);
    endtask

    task automatic t_bcast_off();
        wr(3'd4, 32'h1 << 11);
        frame("R8 broadcast rejected", BCAST, 0);
        frame("R8 station unaffected", STA, 0);
    endtask

    task automatic t_inverse();
        wr(3'd4, 32'h1 << 17);
        frame("R9 inverse rejects station", STA, 0);
        frame("R9 inverse accepts other", OTHER, 0);
    endtask

    task automatic t_promisc();
        wr(3'd4, 32'h1 << 18);
        frame("R10 promiscuous other", OTHER, 0);
        chk("R10 fail still reported", {31'd0, ref_dec(OTHER)[0]}, 32'd1);
        wr(3'd4, 32'h0);
    endtask

    task automatic t_restart();
        for (int i = 0; i < 3; i++) drive_byte(i == 0, OTHER[i*8 +: 8]);
        send(STA, 0);
        check_dec("R11 restart mid-frame", STA);
        for (int i = 0; i < 6; i++) drive_byte(1'b0, STA[i*8 +: 8]);
        idle();
        chk("R11 bytes after sixth ignored", {31'd0, dec_valid}, 32'd0);
        idle();
        chk("R11 still no decision", {31'd0, dec_valid}, 32'd0);
    endtask

    task automatic t_race();
        for (int i = 0; i < 5; i++) drive_byte(i == 0, OTHER[i*8 +: 8]);
        @(negedge clk);
        sof = 1'b0; byte_valid = 1'b1; byte_data = OTHER[47:40];
        reg_we = 1'b1; reg_sel = 3'd4; reg_wdata = 32'h1 << 18;
        @(negedge clk);
        sof = 1'b0; byte_valid = 1'b0; reg_we = 1'b0;
        check_dec("R12 same-cycle write not used", OTHER);
        sh_ctrl = 32'h1 << 18;
        frame("R12 write used next frame", OTHER, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unicast();
        t_flags();
        t_hash();
        t_passall();
        t_hashonly();
        t_bcast_off();
        t_inverse();
        t_promisc();
        t_restart();
        t_race();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule